// File: doc/BRIEF.md
# Two-Level Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using two tables that are read one after the other. The first table holds one short outcome history for each branch. It is selected by low-order bits of the branch's instruction address. The history pattern read from it then selects one 2-bit saturating counter in a second table. The upper bit of that counter is the guess.

A fetch stage raises a request with the branch address and receives the guess two clock cycles later. A later pipeline stage reports each resolved branch with its address and real outcome. That report trains the counter chosen by the branch's old history, then shifts the outcome into the history.

The default configuration has 64 histories of 4 bits and a 16-counter pattern table. Target address generation and recovery of speculative history belong to other blocks.

Top module: `tlp_predictor`

## Requirements
- R1: After a synchronous active-high reset, every history is 0000 and every counter is 01 (weakly not taken), so every prediction made before the first update is not taken (pred_taken = 0).
- R2: pred_vld is 1 exactly two rising edges after a cycle with pred_req = 1, and it is 0 in every other cycle. pred_taken is meaningful only while pred_vld = 1.
- R3: The history entry is selected by pc[7:2] alone. Two addresses that differ only in bits [1:0] or in bits above 7 share one history and give the same prediction.
- R4: An update shifts the selected 4-bit history left by one bit and puts the outcome into bit 0, with taken = 1 and not taken = 0. For example, the outcomes taken, taken, not taken, not taken leave the pattern 1100.
- R5: The 4-bit history value is the address of the pattern-table counter. A counter value of 00 or 01 predicts not taken (0), and 10 or 11 predicts taken (1).
- R6: An update changes the counter addressed by the history as it was before that update's shift.
- R7: An update adds one to the counter when the branch was taken and subtracts one when it was not. The counter stays at 11 on a taken outcome and at 00 on a not-taken outcome.
- R8: A prediction requested in the same cycle as an update to the same history entry reads the history as it was before that update. Its counter read, one edge later, sees that update's counter change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_req | input | 1 | Prediction request |
| pred_pc | input | 32 | Branch instruction address for the request |
| pred_vld | output | 1 | Registered flag: prediction result valid |
| pred_taken | output | 1 | Registered prediction, 1 = taken |
| upd_en | input | 1 | Resolved-branch update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
A prediction is due on the second rising edge after its request. The bench drives each input just after a falling edge. It samples pred_vld after one edge, expecting 0, and samples pred_vld and pred_taken after the second edge, expecting 1 and the model's guess. An update takes effect on the single edge that samples it, so the bench model applies the update at that edge. Any prediction requested afterwards is compared against the new state. The one exception is the same-cycle case, where the expected value combines the old history with the new counter.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

  localparam int CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  // saturating step of a direction counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
    else       nxt = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
    return nxt;
  endfunction

endpackage

// File: rtl/tlp_hist_table.sv
module tlp_hist_table #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_taken,
  output logic [HIST_W-1:0] wr_old
);

  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_mem [DEPTH];

  // pre-shift history of the entry being updated (feeds counter training)
  assign wr_old = hist_mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist_mem[i] <= '0;
    end else if (wr_en) begin
      hist_mem[wr_idx] <= {wr_old[HIST_W-2:0], wr_taken};
    end
  end

  // registered read: returns the value from before a same-edge write
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_hist <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_hist <= hist_mem[rd_idx];
    end
  end

  AST_HIST_NEW_BIT: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hist_mem[$past(wr_idx)][0] == $past(wr_taken)); // R4

  AST_HIST_OLD_MOVES: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hist_mem[$past(wr_idx)][HIST_W-1:1] == $past(wr_old[HIST_W-2:0])); // R4

endmodule

// File: rtl/tlp_pattern_table.sv
module tlp_pattern_table
  import tlp_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_vld,
  output logic              rd_taken,
  input  logic              up_en,
  input  logic [HIST_W-1:0] up_idx,
  input  logic              up_taken
);

  localparam int DEPTH = 1 << HIST_W;

  ctr_t ctr_mem [DEPTH];
  ctr_t up_old;

  assign up_old = ctr_mem[up_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= CTR_WEAK_NT;
    end else if (up_en) begin
      ctr_mem[up_idx] <= ctr_step(up_old, up_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld   <= 1'b0;
      rd_taken <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_taken <= ctr_mem[rd_idx][CTR_W-1];
    end
  end

  AST_CTR_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    up_en |=> ctr_t'(ctr_mem[$past(up_idx)] - $past(up_old)) != 2'd2); // R7

  AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up_en && up_taken && up_old == CTR_MAX) |=> ctr_mem[$past(up_idx)] == CTR_MAX); // R7

  AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up_en && !up_taken && up_old == CTR_MIN) |=> ctr_mem[$past(up_idx)] == CTR_MIN); // R7

endmodule

// File: rtl/tlp_predictor.sv
module tlp_predictor #(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 6,
  parameter int HIST_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_req,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_vld,
  output logic            pred_taken,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  logic [IDX_W-1:0]  pred_idx, upd_idx;
  logic              s1_vld;
  logic [HIST_W-1:0] s1_hist;
  logic [HIST_W-1:0] upd_old_hist;
  logic              unused_pc_bits;

  assign pred_idx = pred_pc[IDX_LSB +: IDX_W];
  assign upd_idx  = upd_pc[IDX_LSB +: IDX_W];
  assign unused_pc_bits = ^{pred_pc, upd_pc};

  // level one: per-branch outcome history
  tlp_hist_table #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) u_hist (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (pred_req),
    .rd_idx   (pred_idx),
    .rd_vld   (s1_vld),
    .rd_hist  (s1_hist),
    .wr_en    (upd_en),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken),
    .wr_old   (upd_old_hist)
  );

  // level two: counters addressed by history pattern
  tlp_pattern_table #(
    .HIST_W (HIST_W)
  ) u_pat (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (s1_vld),
    .rd_idx   (s1_hist),
    .rd_vld   (pred_vld),
    .rd_taken (pred_taken),
    .up_en    (upd_en),
    .up_idx   (upd_old_hist),
    .up_taken (upd_taken)
  );

  AST_RESULT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    pred_vld |-> $past(pred_req, 2)); // R2

  AST_REQ_GETS_RESULT: assert property (@(posedge clk) disable iff (rst)
    pred_req |=> ##1 pred_vld); // R2

endmodule

// File: tb/tlp_predictor_tb.sv
module tlp_predictor_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        pred_req;
  logic [31:0] pred_pc;
  logic        pred_vld;
  logic        pred_taken;
  logic        upd_en;
  logic [31:0] upd_pc;
  logic        upd_taken;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of both tables
  logic [3:0] m_hist [64];
  logic [1:0] m_ctr  [16];

  always #10 clk = ~clk;

  tlp_predictor u_dut (
    .clk(clk), .rst(rst),
    .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_vld(pred_vld), .pred_taken(pred_taken),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // {outcome, pc}: update, then predict the same address
  localparam logic [32:0] VEC [16] = '{
    {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0100},
    {1'b0, 32'h0000_0100}, {1'b1, 32'h0000_0104}, {1'b1, 32'h0000_0104},
    {1'b1, 32'h0000_0104}, {1'b1, 32'h0000_0104}, {1'b1, 32'h0000_0104},
    {1'b1, 32'h0000_01FC}, {1'b0, 32'h0000_01FC}, {1'b1, 32'h0000_01FC},
    {1'b0, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0108},
    {1'b1, 32'h0000_0108}
  };

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic model_pred(input logic [31:0] pc);
    return m_ctr[m_hist[pc[7:2]]][1];
  endfunction

  task automatic model_upd(input logic [31:0] pc, input logic t);
    logic [3:0] h;
    h = m_hist[pc[7:2]];
    m_ctr[h] = step(m_ctr[h], t);
    m_hist[pc[7:2]] = {h[2:0], t};
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pred_req = 1'b0; upd_en = 1'b0;
    pred_pc = '0; upd_pc = '0; upd_taken = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) m_hist[i] = 4'h0;
    for (int i = 0; i < 16; i++) m_ctr[i] = 2'b01;
  endtask

  task automatic do_update(input logic [31:0] pc, input logic t);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_taken = t;
    @(negedge clk);
    upd_en = 1'b0;
    model_upd(pc, t);
  endtask

  // request, then check result two edges later (R2 timing)
  task automatic do_predict(input logic [31:0] pc, input logic exp, input string tag);
    @(negedge clk);
    pred_req = 1'b1; pred_pc = pc;
    @(negedge clk);
    pred_req = 1'b0;
    check(pred_vld, 1'b0, "R2 not valid after one edge");
    @(negedge clk);
    check(pred_vld, 1'b1, "R2 valid after two edges");
    check(pred_taken, exp, tag);
  endtask

  initial begin
    rst = 1'b1;
    do_reset();

    // R1: every prediction before any update is not taken
    check(pred_vld, 1'b0, "R1 reset valid low");
    do_predict(32'h0000_0000, 1'b0, "R1 reset prediction pc 0");
    do_predict(32'h0000_00FC, 1'b0, "R1 reset prediction pc FC");
    @(negedge clk);
    check(pred_vld, 1'b0, "R2 valid drops after one result");

    // table walk: R4 R5 R6 against the model
    for (int v = 0; v < 16; v++) begin
      do_update(VEC[v][31:0], VEC[v][32]);
      do_predict(VEC[v][31:0], model_pred(VEC[v][31:0]), "R4 R5 R6 vector walk");
    end

    // R3 aliasing and R7 saturation
    do_reset();
    for (int k = 0; k < 10; k++) do_update(32'h0000_0040, 1'b1);
    for (int k = 0; k < 6; k++)  do_update(32'h0000_0044, 1'b0);
    do_predict(32'h0000_0040, model_pred(32'h0000_0040), "R7 top saturation taken");
    do_predict(32'h0000_1043, model_pred(32'h0000_0040), "R3 alias on high and low bits");
    do_predict(32'h0000_0044, model_pred(32'h0000_0044), "R3 neighbour entry separate");
    do_predict(32'h0000_0044, 1'b0, "R7 bottom saturation not taken");
    do_update(32'h0000_0040, 1'b0);
    do_update(32'h0000_0040, 1'b1);
    do_update(32'h0000_0040, 1'b1);
    do_update(32'h0000_0040, 1'b1);
    do_update(32'h0000_0040, 1'b1);
    do_predict(32'h0000_0040, model_pred(32'h0000_0040), "R7 held top after one decrement");

    // R6: a branch of pattern 1100 must train counter 1100, not 1001
    do_reset();
    do_update(32'h0000_0080, 1'b1);
    do_update(32'h0000_0080, 1'b1);
    do_update(32'h0000_0080, 1'b0);
    do_update(32'h0000_0080, 1'b0);
    do_update(32'h0000_0084, 1'b1);
    do_update(32'h0000_0084, 1'b1);
    do_update(32'h0000_0084, 1'b0);
    do_update(32'h0000_0084, 1'b0);
    do_update(32'h0000_0080, 1'b1);
    do_update(32'h0000_0084, 1'b1);
    do_update(32'h0000_0088, 1'b1);
    do_update(32'h0000_0088, 1'b1);
    do_update(32'h0000_0088, 1'b0);
    do_update(32'h0000_0088, 1'b0);
    do_predict(32'h0000_0088, model_pred(32'h0000_0088), "R6 pre-shift counter trained");
    do_predict(32'h0000_0088, 1'b1, "R4 R5 pattern 1100 predicts taken");

    // R8: same-cycle request and update to one entry
    begin
      logic [3:0] h_old;
      logic       exp8;
      do_update(32'h0000_00C0, 1'b1);
      h_old = m_hist[6'h30];
      @(negedge clk);
      pred_req = 1'b1; pred_pc = 32'h0000_00C0;
      upd_en = 1'b1; upd_pc = 32'h0000_00C0; upd_taken = 1'b1;
      model_upd(32'h0000_00C0, 1'b1);
      exp8 = m_ctr[h_old][1];
      @(negedge clk);
      pred_req = 1'b0; upd_en = 1'b0;
      @(negedge clk);
      check(pred_vld, 1'b1, "R8 same-cycle result valid");
      check(pred_taken, exp8, "R8 old history with new counter");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule